// File: doc/BRIEF.md
# Multi-mode shift register with signed-overflow flag

This block is a parameterised register (eight bits by default) that changes once per clock edge under a three-bit operation code. The code selects one of eight actions: keep the value, take a new value in parallel, or shift one place. A shift can be arithmetic, logical or circular, and it can go toward the most or the least significant bit. Each operation is a single-cycle step, so a chain of steps is a sequence of op codes applied on consecutive cycles.

The block keeps a sticky overflow flag next to the data. The flag sets when an arithmetic left shift changes the sign bit. When that happens the result is no longer twice the signed operand. Once set, the flag holds through every later shift and hold. Only a parallel load or a reset clears it. Reset is asserted asynchronously and released in step with the clock through a small synchronizer.

Top module: `multimode_shifter`

## Requirements
- R1: While reset is low, and from the moment it falls, the register output and the overflow flag are both 0.
- R2: Op code 000 (hold) leaves both the register and the overflow flag unchanged.
- R3: Op code 001 (load) copies the load data into the register and clears the overflow flag. Under every other op code the load data has no effect.
- R4: Op code 010 (arithmetic shift right) moves every bit one place toward bit 0 and keeps the old MSB in the MSB, so 10011100 becomes 11001110.
- R5: Op code 011 (logical shift left) moves every bit one place toward the MSB, puts 0 in bit 0, and never changes the overflow flag, so 11001110 becomes 10011100.
- R6: Op code 100 (circular shift right) moves every bit one place toward bit 0 and puts the old bit 0 into the MSB, so 10011100 becomes 01001110.
- R7: Op code 101 (circular shift left) moves every bit one place toward the MSB and puts the old MSB into bit 0.
- R8: Op code 110 (arithmetic shift left) produces the same data as R5. It sets the overflow flag when the old MSB differs from the old bit below it, so 01001110 becomes 10011100 with the flag set.
- R9: Once set, the overflow flag stays at 1 under every op code other than load, until a load or a reset.
- R10: Op code 111 (logical shift right) moves every bit one place toward bit 0 and puts 0 in the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register and flag update on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| op_i | input | 3 | Operation code for the next edge |
| load_data_i | input | W (8) | Value taken on a load |
| data_o | output | W (8) | Current register contents |
| ovf_o | output | 1 | Sticky signed-overflow flag |

## Verification
On every cycle the assertions check how each op code moves the register from one value to the next: hold, load, each of the shifts with its fill bit, the setting of the overflow flag on a sign change, its persistence under non-load codes, and that it stays clear when nothing sets it. The bench's scenarios are needed for the rest. These are the asynchronous clear when reset falls in mid-run, the delayed release through the synchronizer, the worked chain that starts from 10011100, and an exhaustive sweep of every starting value under every op code with the load data driven to a different value.

// File: rtl/mms_pkg.sv
package mms_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_ASR  = 3'd2,
    OP_LSL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_ROL  = 3'd5,
    OP_ASL  = 3'd6,
    OP_LSR  = 3'd7
  } op_e;
endpackage

// File: rtl/mms_rst_sync.sv
// Asserts asynchronously, releases after STAGES rising edges.
module mms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mms_shift_unit.sv
// Combinational next-value logic for the data register.
module mms_shift_unit
  import mms_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt,
  output logic         en,
  output logic         sign_flip,
  output logic         is_load
);
  localparam int MSB = W - 1;

  logic [W-1:0] up_zero;   // one place toward MSB, zero fill
  logic [W-1:0] dn_fill;   // one place toward bit 0, fill chosen below
  logic         dn_in;

  assign up_zero = {cur[MSB-1:0], 1'b0};

  always_comb begin
    unique case (op)
      OP_ASR:  dn_in = cur[MSB];
      OP_ROR:  dn_in = cur[0];
      default: dn_in = 1'b0;
    endcase
  end

  assign dn_fill = {dn_in, cur[MSB:1]};

  always_comb begin
    nxt = cur;
    unique case (op)
      OP_HOLD: nxt = cur;
      OP_LOAD: nxt = din;
      OP_ASR,
      OP_ROR,
      OP_LSR:  nxt = dn_fill;
      OP_LSL,
      OP_ASL:  nxt = up_zero;
      OP_ROL:  nxt = {cur[MSB-1:0], cur[MSB]};
      default: nxt = cur;
    endcase
  end

  assign en        = (op != OP_HOLD);
  assign is_load   = (op == OP_LOAD);
  assign sign_flip = (op == OP_ASL) && (cur[MSB] ^ cur[MSB-1]);
endmodule

// File: rtl/mms_ovf_flag.sv
// Sticky overflow bit: set by a sign change, cleared by load.
module mms_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = clr_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/multimode_shifter.sv
module multimode_shifter
  import mms_pkg::*;
#(
  parameter int W          = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  logic         rst_sync_n;
  op_e          op_dec;
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;
  logic         data_en;
  logic         sign_flip;
  logic         is_load;

  assign op_dec = op_e'(op_i);

  mms_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mms_shift_unit #(.W(W)) u_shift (
    .op        (op_dec),
    .cur       (data_q),
    .din       (load_data_i),
    .nxt       (data_d),
    .en        (data_en),
    .sign_flip (sign_flip),
    .is_load   (is_load)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  mms_ovf_flag u_ovf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (sign_flip),
    .clr_i  (is_load),
    .flag_o (ovf_o)
  );

  assign data_o = data_q;
endmodule

// File: rtl/mms_checker.sv
module mms_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         ovf
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 |=> $stable(q) && $stable(ovf));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd1 |=> q == $past(din) && !ovf);

  assert_asr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd2 |=> q == {$past(q[W-1]), $past(q[W-1:1])});

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'd6) && !ovf |=> !ovf);

  assert_ror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd4 |=> q == {$past(q[0]), $past(q[W-1:1])});

  assert_rol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd5 |=> q == {$past(q[W-2:0]), $past(q[W-1])});

  assert_asl_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd6 && (q[W-1] != q[W-2]) |=> ovf && q[0] == 1'b0);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && op != 3'd1 |=> ovf);

  assert_lsr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd7 |=> q == {1'b0, $past(q[W-1:1])});
endmodule

bind multimode_shifter mms_checker #(.W(W)) u_chk (
  .clk (clk),
  .rst_n (rst_sync_n),
  .op  (op_i),
  .din (load_data_i),
  .q   (data_o),
  .ovf (ovf_o)
);

// File: tb/tb_multimode_shifter.sv
`timescale 1ns/1ps
module tb_multimode_shifter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op;
  logic [7:0] din;
  logic [7:0] q;
  logic       ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  multimode_shifter #(.W(8)) dut (
    .clk (clk), .rst_n (rst_n), .op_i (op), .load_data_i (din),
    .data_o (q), .ovf_o (ovf)
  );

  function automatic string tag_of(int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  // Reference model computed arithmetically.
  task automatic model(input int o, input int v, input int d, input int f,
                       output int nv, output int nf);
    nv = v; nf = f;
    case (o)
      0: ;
      1: begin nv = d; nf = 0; end
      2: nv = (v / 2) + ((v >= 128) ? 128 : 0);
      3: nv = (v * 2) % 256;
      4: nv = (v / 2) + (v % 2) * 128;
      5: nv = (v * 2) % 256 + v / 128;
      6: begin nv = (v * 2) % 256; if (v >= 64 && v < 192) nf = 1; end
      default: nv = v / 2;
    endcase
  endtask

  task automatic chk(string req, int aq, int eq, int ao, int eo);
    checks++;
    if (aq != eq || ao != eo) begin
      errors++;
      $display("FAIL %s: data=%b ovf=%0d expected data=%b ovf=%0d",
               req, aq[7:0], ao, eq[7:0], eo);
    end
  endtask

  // Apply one op at a negedge; result is visible at the next negedge.
  task automatic step(input int o, input int d);
    op = o[2:0]; din = d[7:0];
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: data=%b ovf=%0d expected run to end", q, ovf);
    finish_run();
  end

  initial begin
    int nv, nf, v;
    rst_n = 1'b0; op = 3'd0; din = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R1", q, 0, ovf, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", q, 0, ovf, 0);

    // Worked chain from 10011100.
    step(1, 8'b10011100); chk("R3", q, 8'b10011100, ovf, 0);
    step(2, 8'h00);       chk("R4", q, 8'b11001110, ovf, 0);
    step(3, 8'hFF);       chk("R5", q, 8'b10011100, ovf, 0);
    step(4, 8'h00);       chk("R6", q, 8'b01001110, ovf, 0);
    step(6, 8'h00);       chk("R8", q, 8'b10011100, ovf, 1);

    // Sticky flag through every non-load op.
    v = 8'b10011100;
    for (int o = 0; o < 8; o++) begin
      if (o == 1) continue;
      model(o, v, 0, 1, nv, nf);
      step(o, 8'h00);
      chk("R9", q, nv, ovf, 1);
      v = nv;
    end
    step(1, 8'h3C); chk("R3", q, 8'h3C, ovf, 0);

    // Exhaustive sweep: every start value under every op.
    for (int s = 0; s < 256; s++) begin
      for (int o = 0; o < 8; o++) begin
        step(1, s);
        chk("R3", q, s, ovf, 0);
        model(o, s, (~s) & 8'hFF, 0, nv, nf);
        step(o, (~s) & 8'hFF);
        chk(tag_of(o), q, nv, ovf, nf);
      end
    end

    // Mid-run reset clears at once.
    step(1, 8'h40); step(6, 8'h00); chk("R8", q, 8'h80, ovf, 1);
    #1 rst_n = 1'b0; #1;
    chk("R1", q, 0, ovf, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", q, 0, ovf, 0);

    finish_run();
  end
endmodule